// File: doc/BRIEF.md
# Bus-Injected Boot Image Loader

This controller stands on a 6502-family processor bus where a ROM would normally sit. After a system reset it keeps the processor clock running while it holds the processor's reset line low. It then releases reset and waits for the processor to fetch its reset vector. It answers that fetch with a fixed dummy start address. From then on it is the only source of instructions. Every opcode and operand fetch is answered with bytes it generates itself, so the processor runs a synthetic program that copies an internal boot image into SRAM, one byte at a time.

For each image byte the generated program is a load-accumulator-immediate that carries the byte, followed by a store-absolute to the byte's target address. The SRAM chip select is opened only in the write cycle of the store. Every 256 bytes a jump-absolute sends the program counter back to the dummy start address, so the program counter stays inside a small window. After the last byte the controller issues an indirect jump through the reset vector location and becomes passive. From then on the SRAM is selected for every access and the controller no longer drives the data bus.

The sequencer is one state machine. Its states are S_HOLD (reset held), S_AWAIT_VEC (waiting for the vector fetch), S_VEC_HI, S_LDA_OP, S_LDA_IMM, S_STA_OP, S_STA_LO, S_STA_HI, S_STA_WR, S_JMP_OP, S_JMP_LO, S_JMP_HI, S_IND_OP, S_IND_LO, S_IND_HI and S_PASSIVE.

Its transitions:
- S_HOLD to S_AWAIT_VEC once reset is released.
- S_AWAIT_VEC to S_VEC_HI when a read of $FFFC ends.
- Each later state moves to the next at the end of every bus cycle.
- S_STA_WR goes to S_IND_OP after the last byte, to S_JMP_OP at the end of a page, and otherwise to S_LDA_OP.
- S_JMP_HI returns to S_LDA_OP.
- S_IND_HI goes to S_PASSIVE, which is left only by a system reset.

Top module: `boot_injector`

## Requirements
- R1: After system reset `cpu_res_n` stays low for exactly HOLD_CYCLES (default 8) bus cycles and then stays high. `cpu_phi0` toggles on every `clk` edge throughout, so one bus cycle is a low half followed by a high half. `cpu_res_n` rises only at the end of a bus cycle.
- R2: A read of $FFFC is answered with the low byte of START_ADDR (default $F000), and the following read of $FFFD with its high byte. The SRAM is not selected in either cycle.
- R3: Image byte i is delivered as the sequence $A9, byte, $8D, low, high. Here {high, low} is TARGET_BASE+i (default base $0300), and the store's write cycle follows. Bytes are delivered in ascending order of i.
- R4: Before handover, `sram_ce_n` is low only in the high half of a store write cycle. `bus_drive` is high on every other read cycle and never while the processor writes.
- R5: After the byte with index 255, 511 and so on (unless it is the last byte), the controller issues $4C followed by the low and then the high byte of START_ADDR.
- R6: After the last byte the controller issues $6C, $FC, $FF. The two pointer reads that follow are served by the SRAM.
- R7: After handover `boot_done` is high and stays high until the next system reset. `bus_drive` is low, and `sram_ce_n` is low in the high half of every bus cycle, for reads and for writes. During reset `boot_done` is low.
- R8: The image has IMAGE_BYTES (default 600) entries. Entry i equals ((29·i + 91) mod 256) XOR floor(i/256). After handover the SRAM holds every entry at TARGET_BASE+i.
- R9: From reset release until the vector fetch, reads of any address other than $FFFC are answered with the filler byte $EA, with the SRAM deselected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock; two periods make one processor bus cycle |
| rst_n | input | 1 | Active-low system reset |
| cpu_addr | input | 16 | Processor address bus |
| cpu_rw | input | 1 | Processor read (1) / write (0) |
| cpu_phi0 | output | 1 | Processor clock; the high half carries the data transfer |
| cpu_res_n | output | 1 | Active-low processor reset |
| bus_dout | output | 8 | Byte the controller places on the data bus |
| bus_drive | output | 1 | Enables `bus_dout` onto the data bus |
| sram_ce_n | output | 1 | Active-low SRAM chip select |
| boot_done | output | 1 | High once the image is loaded and control is handed over |

## Verification
The assertions take for granted that the processor keeps its address and read/write line steady across the clock edge that ends each bus cycle. They also assume that a read of $FFFD follows directly on the read of $FFFC, and that the store's final cycle really is a write. The bench meets these assumptions with a small instruction-level processor model. The model takes exactly 2, 4, 3 and 5 bus cycles for the four instructions in use. It performs five dummy reads after reset and then the two vector reads, and it changes its address only in the low half of a cycle.

// File: rtl/bl_pkg.sv
package bl_pkg;

    localparam logic [7:0] OP_LDA_IMM = 8'hA9;
    localparam logic [7:0] OP_STA_ABS = 8'h8D;
    localparam logic [7:0] OP_JMP_ABS = 8'h4C;
    localparam logic [7:0] OP_JMP_IND = 8'h6C;

    localparam logic [15:0] VEC_LO_ADDR = 16'hFFFC;
    localparam logic [15:0] VEC_HI_ADDR = 16'hFFFD;

    typedef enum logic [3:0] {
        S_HOLD,
        S_AWAIT_VEC,
        S_VEC_HI,
        S_LDA_OP,
        S_LDA_IMM,
        S_STA_OP,
        S_STA_LO,
        S_STA_HI,
        S_STA_WR,
        S_JMP_OP,
        S_JMP_LO,
        S_JMP_HI,
        S_IND_OP,
        S_IND_LO,
        S_IND_HI,
        S_PASSIVE
    } seq_state_t;

    // Content of boot image entry i.
    function automatic logic [7:0] image_byte(input int unsigned i);
        logic [31:0] mix;
        mix = i * 32'd29 + 32'd91;
        return mix[7:0] ^ 8'(i >> 8);
    endfunction

endpackage

// File: rtl/bl_clkgen.sv
module bl_clkgen #(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic phi0,
    output logic cyc_end,
    output logic res_n
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);

    logic [CW-1:0] hold_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phi0     <= 1'b0;
            res_n    <= 1'b0;
            hold_cnt <= '0;
        end else begin
            phi0 <= ~phi0;
            if (phi0 && !res_n) begin
                if (hold_cnt == CW'(HOLD_CYCLES - 1))
                    res_n <= 1'b1;
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

    // A bus cycle ends on the edge where phi0 falls.
    assign cyc_end = phi0;

    // R1: reset is released only on the edge that ends a bus cycle
    assert_res_at_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_n) |-> !phi0);

    // R1: once released, reset stays released
    assert_res_no_reassert_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_n |=> res_n);

endmodule

// File: rtl/bl_addr_ctr.sv
module bl_addr_ctr #(
    parameter int          IMAGE_BYTES = 600,
    parameter int          PAGE_BYTES  = 256,
    parameter logic [15:0] TARGET_BASE = 16'h0300,
    parameter int          IDX_W       = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic [15:0]      tgt_addr,
    output logic             is_last,
    output logic             page_end
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IMAGE_BYTES - 1);

    logic [31:0] idx_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx <= '0;
        else if (step && !is_last)
            idx <= idx + 1'b1;
    end

    always_comb begin
        idx_next = 32'(idx) + 32'd1;
        tgt_addr = TARGET_BASE + 16'(idx);
        is_last  = (idx == LAST_IDX);
        page_end = ((idx_next % PAGE_BYTES) == 32'd0);
    end

    // R8: the index never leaves the image
    assert_idx_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST_IDX);

    // R3: each completed store moves on to the next byte
    assert_step_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !is_last) |=> (idx == $past(idx) + 1'b1));

endmodule

// File: rtl/bl_image.sv
module bl_image #(
    parameter int IMAGE_BYTES = 600,
    parameter int IDX_W       = 10
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       data
);
    import bl_pkg::*;

    logic [7:0] rom [IMAGE_BYTES];

    for (genvar g = 0; g < IMAGE_BYTES; g++) begin : g_rom
        assign rom[g] = image_byte(g);
    end

    assign data = rom[idx];

endmodule

// File: rtl/bl_seq.sv
module bl_seq #(
    parameter logic [15:0] START_ADDR = 16'hF000,
    parameter logic [7:0]  FILLER     = 8'hEA
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        phi0,
    input  logic        cyc_end,
    input  logic        res_n,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rw,
    input  logic        is_last,
    input  logic        page_end,
    input  logic [7:0]  img_data,
    input  logic [15:0] tgt_addr,
    output logic        step,
    output logic [7:0]  bus_dout,
    output logic        bus_drive,
    output logic        sram_ce_n,
    output logic        done
);
    import bl_pkg::*;

    seq_state_t state, nxt;
    logic       drv;
    logic       sel;
    logic [7:0] dat;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_HOLD;
        else
            state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_HOLD:      if (res_n) nxt = S_AWAIT_VEC;
            S_AWAIT_VEC: if (cyc_end && cpu_rw && cpu_addr == VEC_LO_ADDR) nxt = S_VEC_HI;
            S_VEC_HI:    if (cyc_end) nxt = S_LDA_OP;
            S_LDA_OP:    if (cyc_end) nxt = S_LDA_IMM;
            S_LDA_IMM:   if (cyc_end) nxt = S_STA_OP;
            S_STA_OP:    if (cyc_end) nxt = S_STA_LO;
            S_STA_LO:    if (cyc_end) nxt = S_STA_HI;
            S_STA_HI:    if (cyc_end) nxt = S_STA_WR;
            S_STA_WR: begin
                if (cyc_end) begin
                    if (is_last)
                        nxt = S_IND_OP;
                    else if (page_end)
                        nxt = S_JMP_OP;
                    else
                        nxt = S_LDA_OP;
                end
            end
            S_JMP_OP:    if (cyc_end) nxt = S_JMP_LO;
            S_JMP_LO:    if (cyc_end) nxt = S_JMP_HI;
            S_JMP_HI:    if (cyc_end) nxt = S_LDA_OP;
            S_IND_OP:    if (cyc_end) nxt = S_IND_LO;
            S_IND_LO:    if (cyc_end) nxt = S_IND_HI;
            S_IND_HI:    if (cyc_end) nxt = S_PASSIVE;
            S_PASSIVE:   nxt = S_PASSIVE;
            default:     nxt = S_HOLD;
        endcase
    end

    // Outputs
    always_comb begin
        drv = 1'b1;
        sel = 1'b0;
        dat = FILLER;
        unique case (state)
            S_HOLD, S_AWAIT_VEC: dat = (cpu_addr == VEC_LO_ADDR) ? START_ADDR[7:0] : FILLER;
            S_VEC_HI:  dat = START_ADDR[15:8];
            S_LDA_OP:  dat = OP_LDA_IMM;
            S_LDA_IMM: dat = img_data;
            S_STA_OP:  dat = OP_STA_ABS;
            S_STA_LO:  dat = tgt_addr[7:0];
            S_STA_HI:  dat = tgt_addr[15:8];
            S_STA_WR: begin
                drv = 1'b0;
                sel = 1'b1;
                dat = 8'h00;
            end
            S_JMP_OP:  dat = OP_JMP_ABS;
            S_JMP_LO:  dat = START_ADDR[7:0];
            S_JMP_HI:  dat = START_ADDR[15:8];
            S_IND_OP:  dat = OP_JMP_IND;
            S_IND_LO:  dat = VEC_LO_ADDR[7:0];
            S_IND_HI:  dat = VEC_LO_ADDR[15:8];
            S_PASSIVE: begin
                drv = 1'b0;
                sel = 1'b1;
                dat = 8'h00;
            end
            default:   dat = FILLER;
        endcase
        bus_drive = drv && cpu_rw;
        bus_dout  = drv ? dat : 8'h00;
        sram_ce_n = !(sel && phi0);
        step      = cyc_end && (state == S_STA_WR);
        done      = (state == S_PASSIVE);
    end

    // R4: during boot the SRAM is opened only for the processor's store
    assert_ce_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && !done) |-> !cpu_rw);

    // R2: the vector high byte is answered only for a read of $FFFD
    assert_vec_hi_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_VEC_HI && cyc_end) |-> (cpu_rw && cpu_addr == VEC_HI_ADDR));

    // R7: handover is permanent until reset
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R6: handover is entered only from the last indirect-jump fetch
    assert_handover_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state) == S_IND_HI));

endmodule

// File: rtl/boot_injector.sv
module boot_injector #(
    parameter int          IMAGE_BYTES = 600,
    parameter int          PAGE_BYTES  = 256,
    parameter int          HOLD_CYCLES = 8,
    parameter logic [15:0] START_ADDR  = 16'hF000,
    parameter logic [15:0] TARGET_BASE = 16'h0300,
    parameter logic [7:0]  FILLER      = 8'hEA
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rw,
    output logic        cpu_phi0,
    output logic        cpu_res_n,
    output logic [7:0]  bus_dout,
    output logic        bus_drive,
    output logic        sram_ce_n,
    output logic        boot_done
);
    localparam int IDX_W = (IMAGE_BYTES > 1) ? $clog2(IMAGE_BYTES) : 1;

    logic             cyc_end;
    logic             step;
    logic [IDX_W-1:0] idx;
    logic [15:0]      tgt_addr;
    logic             is_last;
    logic             page_end;
    logic [7:0]       img_data;

    bl_clkgen #(.HOLD_CYCLES(HOLD_CYCLES)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .phi0    (cpu_phi0),
        .cyc_end (cyc_end),
        .res_n   (cpu_res_n)
    );

    bl_addr_ctr #(
        .IMAGE_BYTES (IMAGE_BYTES),
        .PAGE_BYTES  (PAGE_BYTES),
        .TARGET_BASE (TARGET_BASE),
        .IDX_W       (IDX_W)
    ) u_addr_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .idx      (idx),
        .tgt_addr (tgt_addr),
        .is_last  (is_last),
        .page_end (page_end)
    );

    bl_image #(.IMAGE_BYTES(IMAGE_BYTES), .IDX_W(IDX_W)) u_image (
        .idx  (idx),
        .data (img_data)
    );

    bl_seq #(.START_ADDR(START_ADDR), .FILLER(FILLER)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .phi0      (cpu_phi0),
        .cyc_end   (cyc_end),
        .res_n     (cpu_res_n),
        .cpu_addr  (cpu_addr),
        .cpu_rw    (cpu_rw),
        .is_last   (is_last),
        .page_end  (page_end),
        .img_data  (img_data),
        .tgt_addr  (tgt_addr),
        .step      (step),
        .bus_dout  (bus_dout),
        .bus_drive (bus_drive),
        .sram_ce_n (sram_ce_n),
        .done      (boot_done)
    );

endmodule

// File: tb/boot_injector_test.sv
module boot_injector_test;

    localparam int          IMG   = 600;
    localparam int          HOLD  = 8;
    localparam logic [15:0] START = 16'hF000;
    localparam logic [15:0] BASE  = 16'h0300;
    localparam int          RAMSZ = 1024;

    // Expected first 14 bus cycles from the vector fetch: {drive, ce_n, data}
    localparam logic [9:0] EXP_TRACE [14] = '{
        {1'b1, 1'b1, 8'h00}, {1'b1, 1'b1, 8'hF0},
        {1'b1, 1'b1, 8'hA9}, {1'b1, 1'b1, 8'h5B},
        {1'b1, 1'b1, 8'h8D}, {1'b1, 1'b1, 8'h00}, {1'b1, 1'b1, 8'h03},
        {1'b0, 1'b0, 8'h00},
        {1'b1, 1'b1, 8'hA9}, {1'b1, 1'b1, 8'h78},
        {1'b1, 1'b1, 8'h8D}, {1'b1, 1'b1, 8'h01}, {1'b1, 1'b1, 8'h03},
        {1'b0, 1'b0, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h01FF;
    logic        cpu_rw = 1'b1;
    logic        cpu_phi0, cpu_res_n, bus_drive, sram_ce_n, boot_done;
    logic [7:0]  bus_dout;

    boot_injector uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_rw    (cpu_rw),
        .cpu_phi0  (cpu_phi0),
        .cpu_res_n (cpu_res_n),
        .bus_dout  (bus_dout),
        .bus_drive (bus_drive),
        .sram_ce_n (sram_ce_n),
        .boot_done (boot_done)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [7:0] ram [RAMSZ];

    // bus-cycle observations
    logic       s_drive, s_ce_n, s_res_n;
    logic [7:0] s_data;
    int  phase_err = 0, contention = 0, stray_ce = 0, stray_wr = 0;
    int  undriven_rd = 0;
    bit  tracing = 1'b0;
    int  tr_n = 0;
    logic [9:0] trace [14];

    function automatic logic [7:0] img(input int i);
        int v;
        v = (i * 29 + 91) % 256;
        return 8'(v) ^ 8'(i / 256);
    endfunction

    function automatic logic [7:0] ram_rd(input logic [15:0] a);
        if (a >= BASE && a < BASE + 16'(RAMSZ)) return ram[a - BASE];
        if (a == 16'hFFFC) return 8'h00;
        if (a == 16'hFFFD) return BASE[15:8];
        return 8'h00;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One processor bus cycle: address in the low half, transfer in the high half.
    task automatic bus(input logic [15:0] a, input logic rw, input logic [7:0] wd,
                       output logic [7:0] rd);
        @(negedge clk);
        cpu_addr = a;
        cpu_rw   = rw;
        @(negedge clk);
        if (!cpu_phi0) phase_err++;
        s_drive = bus_drive;
        s_ce_n  = sram_ce_n;
        s_res_n = cpu_res_n;
        s_data  = bus_dout;
        if (s_drive && !rw) contention++;
        if (s_drive && !s_ce_n) contention++;
        if (!boot_done && !s_ce_n && rw) stray_ce++;
        if (s_drive) rd = s_data;
        else if (!s_ce_n && rw) rd = ram_rd(a);
        else begin
            rd = 8'h00;
            if (rw) undriven_rd++;
        end
        if (!s_ce_n && !rw) begin
            if (a >= BASE && a < BASE + 16'(RAMSZ)) ram[a - BASE] = wd;
            else stray_wr++;
        end
        if (tracing && tr_n < 14) begin
            trace[tr_n] = {s_drive, s_ce_n, s_drive ? s_data : 8'h00};
            tr_n++;
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd, lo, hi, op, acc, pl, ph;
        logic [15:0] pc, ptr;
        int hold_seen, filler_bad, n_sta, n_jmp, jmp_bad, order_bad, page_bad;
        int max_off, bad_op, ram_bad;
        bit ind_seen;

        for (int i = 0; i < RAMSZ; i++) ram[i] = 8'hFF;

        // Reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(cpu_res_n == 1'b0, "R1", "cpu_res_n in reset", int'(cpu_res_n), 0);
        check(boot_done == 1'b0, "R7", "boot_done in reset", int'(boot_done), 0);
        check(sram_ce_n == 1'b1, "R4", "sram_ce_n in reset", int'(sram_ce_n), 1);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset hold: count cycles with the processor reset low (R1, R9)
        hold_seen  = 0;
        filler_bad = 0;
        do begin
            bus(16'h01FF, 1'b1, 8'h00, rd);
            if (!s_res_n) hold_seen++;
            if (rd != 8'hEA || !s_drive || !s_ce_n) filler_bad++;
        end while (!s_res_n && hold_seen < 1000);
        check(hold_seen == HOLD, "R1", "cycles with reset held", hold_seen, HOLD);
        check(phase_err == 0, "R1", "phi0 high-half misalignments", phase_err, 0);
        // four more dummy reads of the reset sequence
        for (int k = 0; k < 4; k++) begin
            bus(16'h01FE - 16'(k), 1'b1, 8'h00, rd);
            if (rd != 8'hEA || !s_drive || !s_ce_n) filler_bad++;
        end
        check(filler_bad == 0, "R9", "filler reads before vector", filler_bad, 0);

        // Vector fetch
        tracing = 1'b1;
        bus(16'hFFFC, 1'b1, 8'h00, lo);
        bus(16'hFFFD, 1'b1, 8'h00, hi);
        pc = {hi, lo};
        check(pc == START, "R2", "start address from vector", int'(pc), int'(START));

        // Instruction-level processor model
        acc = 8'h00; n_sta = 0; n_jmp = 0; jmp_bad = 0; order_bad = 0;
        page_bad = 0; max_off = 0; bad_op = 0; ind_seen = 1'b0; ptr = 16'h0000;
        for (int step_i = 0; step_i < 4000 && !ind_seen && bad_op == 0; step_i++) begin
            if (int'(pc) - int'(START) > max_off) max_off = int'(pc) - int'(START);
            bus(pc, 1'b1, 8'h00, op);
            pc = pc + 16'd1;
            case (op)
                8'hA9: begin
                    bus(pc, 1'b1, 8'h00, acc);
                    pc = pc + 16'd1;
                end
                8'h8D: begin
                    bus(pc, 1'b1, 8'h00, lo); pc = pc + 16'd1;
                    bus(pc, 1'b1, 8'h00, hi); pc = pc + 16'd1;
                    if ({hi, lo} != BASE + 16'(n_sta)) order_bad++;
                    bus({hi, lo}, 1'b0, acc, rd);
                    n_sta++;
                end
                8'h4C: begin
                    bus(pc, 1'b1, 8'h00, lo); pc = pc + 16'd1;
                    bus(pc, 1'b1, 8'h00, hi);
                    if ({hi, lo} != START) jmp_bad++;
                    if (n_sta % 256 != 0) page_bad++;
                    pc = {hi, lo};
                    n_jmp++;
                end
                8'h6C: begin
                    bus(pc, 1'b1, 8'h00, lo); pc = pc + 16'd1;
                    bus(pc, 1'b1, 8'h00, hi);
                    ptr = {hi, lo};
                    bus(ptr, 1'b1, 8'h00, pl);
                    bus(ptr + 16'd1, 1'b1, 8'h00, ph);
                    pc = {ph, pl};
                    ind_seen = 1'b1;
                end
                default: bad_op++;
            endcase
        end
        tracing = 1'b0;

        // Opening sequence against the vector table (R2, R3, R4)
        check(tr_n == 14, "R3", "trace length", tr_n, 14);
        for (int t = 0; t < 14; t++)
            check(trace[t] == EXP_TRACE[t], "R3", $sformatf("bus cycle %0d", t),
                  int'(trace[t]), int'(EXP_TRACE[t]));

        check(bad_op == 0, "R3", "unexpected opcodes", bad_op, 0);
        check(n_sta == IMG, "R3", "stores issued", n_sta, IMG);
        check(order_bad == 0, "R3", "store target order errors", order_bad, 0);
        check(n_jmp == 2, "R5", "page jumps", n_jmp, 2);
        check(jmp_bad == 0, "R5", "page jump target errors", jmp_bad, 0);
        check(page_bad == 0, "R5", "page jumps off a 256-byte boundary", page_bad, 0);
        check(max_off < 1285, "R5", "program counter window", max_off, 1284);
        check(ind_seen && ptr == 16'hFFFC, "R6", "indirect jump pointer", int'(ptr), 16'hFFFC);
        check(pc == BASE, "R6", "entry point read from SRAM vector", int'(pc), int'(BASE));
        check(stray_ce == 0, "R4", "SRAM selected on boot reads", stray_ce, 0);
        check(contention == 0, "R4", "drive during write or select", contention, 0);
        check(undriven_rd == 0, "R4", "reads left undriven", undriven_rd, 0);
        check(stray_wr == 0, "R4", "writes outside SRAM window", stray_wr, 0);
        check(boot_done == 1'b1, "R7", "boot_done after handover", int'(boot_done), 1);

        // Image contents (R8)
        ram_bad = 0;
        for (int i = 0; i < IMG; i++) begin
            checks++;
            if (ram[i] != img(i)) begin
                fails++;
                ram_bad++;
                $display("FAIL R8 ram[%0h]: actual %0h expected %0h", BASE + 16'(i), ram[i], img(i));
            end
        end

        // Passive operation (R7)
        bus(pc, 1'b1, 8'h00, rd);
        check(s_drive == 1'b0, "R7", "no drive after handover", int'(s_drive), 0);
        check(s_ce_n == 1'b0, "R7", "SRAM selected on read", int'(s_ce_n), 0);
        check(rd == img(0), "R7", "read served by SRAM", int'(rd), int'(img(0)));
        bus(BASE + 16'd700, 1'b0, 8'h3C, rd);
        check(s_ce_n == 1'b0, "R7", "SRAM selected on write", int'(s_ce_n), 0);
        bus(BASE + 16'd700, 1'b1, 8'h00, rd);
        check(rd == 8'h3C, "R7", "written byte read back", int'(rd), 16'h3C);
        bus(16'hFFFC, 1'b1, 8'h00, rd);
        check(s_drive == 1'b0 && rd == 8'h00, "R7", "vector read from SRAM after handover",
              int'(rd), 0);
        check(boot_done == 1'b1, "R7", "boot_done held", int'(boot_done), 1);

        // Reset again mid-operation (R1, R7)
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(boot_done == 1'b0, "R7", "boot_done cleared by reset", int'(boot_done), 0);
        check(cpu_res_n == 1'b0, "R1", "processor reset reasserted", int'(cpu_res_n), 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule